// File: doc/BRIEF.md
# Miss Request Table with Same-Line Merging

This block keeps track of the line fetches that are outstanding on one shared bus. It handles plain line reads, exclusive reads and upgrades. Each active table entry holds a line address, the request that owns the entry (the initiator), a set of requests merged onto it, and an ordered list of requests held back behind it. Other requests wait in a pending pool, which records each request's ID, command and address, until one of them wins the bus and is inserted into the table.

The block accepts one operation per cycle. A queue operation adds a request to the pending pool. An insert operation gives a table entry to a request. When it does, the block sorts every pending request to the same line: a compatible read joins the merge set, a conflicting access joins the hold list, and a writeback stays where it is. If the insert used the last free entry, pending reads and exclusive reads to other lines are marked as waiting for table space. A complete operation answers the initiator, together with every merged request when the initiator is a read, in one response event. It then either hands the entry to the oldest held request, which re-arbitrates, or frees the entry and lets the oldest table-space waiter re-arbitrate.

The upstream logic serialises competing operations, with completions first. The bus and memory timing around the block are not modelled here.

Top module: `miss_merge_table`

## Requirements
- R1: After reset no response or arbitrate event is raised, and both event counters read zero.
- R2: An insert takes the lowest-numbered unused entry. The response to a completion reports, on `respEntry`, the entry index that the initiator held. An insert while no entry is free has no effect.
- R3: On insert, a pending read (command 0) to the same address joins the merge set when `opShared` is 1. At completion of a read initiator, the initiator and all merged requests are answered in a single response. The response carries one bit per ID in `respMask`, and all answered requests share the completion's status and data.
- R4: On insert, the following pending requests to the same address join the hold list in arrival order: a read when `opShared` is 0, an exclusive read (command 1), and an upgrade (command 2). When the initiator completes and the list is not empty, the head becomes the new initiator. An arbitrate event carries the head's ID and command and the entry's address, and `conflictCount` rises by one.
- R5: When the promoted request is a read, every other held read joins the merge set and is answered with it. Held non-read requests keep their order.
- R6: A pending writeback (command 3) to the inserted address is neither merged nor held. It is never answered or released by the table.
- R7: When an insert takes the last free entry, every pending read or exclusive read to another address is marked as waiting for space. Upgrades and writebacks are not marked. When a completion frees an entry, the waiter that arrived earliest is removed from the pool and signalled with an arbitrate event.
- R8: Requests waiting for table space are scanned like other pending requests. A later insert to the same address merges or holds them instead of releasing them.
- R9: `mergeCount` rises by the number of merged requests answered at each completion, not counting the initiator.
- R10: A completion whose ID owns no entry raises no event and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opKind | input | 2 | 0 none, 1 queue, 2 insert, 3 complete |
| opId | input | ID_W | Request ID of the operation |
| opCmd | input | 2 | 0 read, 1 exclusive read, 2 upgrade, 3 writeback |
| opShared | input | 1 | Insert: initiator wants the line shared |
| opAddr | input | ADDR_W | Line address |
| opStatus | input | STAT_W | Completion status |
| opData | input | DATA_W | Completion data tag |
| respValid | output | 1 | Response event, one cycle after a matching completion |
| respMask | output | 2**ID_W | One bit per answered request ID |
| respStatus | output | STAT_W | Status given to every answered request |
| respData | output | DATA_W | Data given to every answered request |
| respEntry | output | clog2(ENTRIES) | Entry that the completed initiator held |
| arbValid | output | 1 | Arbitrate request event |
| arbId | output | ID_W | Request that must arbitrate |
| arbCmd | output | 2 | Its command |
| arbAddr | output | ADDR_W | Its address |
| mergeCount | output | CNT_W | Merged answers so far |
| conflictCount | output | CNT_W | Promotions from hold lists so far |

## Verification
On every cycle the assertions check several event rules. Responses and arbitrate events only follow a completion. A response always answers at least one request. The conflict counter only steps by one, and only together with an arbitrate event. The merge counter only moves with a response. The sorting rules are shown by the bench's scenarios: which pending request merges, holds or is left alone, the arrival order of the hold list and of the table-space waiters, the lowest-free-entry choice, and merging a request that was waiting for space.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    CMD_GET       = 2'd0,
    CMD_GETX      = 2'd1,
    CMD_UPGRADE   = 2'd2,
    CMD_WRITEBACK = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_QUEUE    = 2'd1,
    OP_INSERT   = 2'd2,
    OP_COMPLETE = 2'd3
  } op_e;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic queuePush;
    logic insertEntry;
    logic completeEntry;
    logic promoteHead;
    logic releaseWaiter;
  } ctrlStrobe_t;

endpackage

// File: rtl/mmt_pending.sv
module mmt_pending
  import mmt_pkg::*;
#(
  parameter int PEND   = 8,
  parameter int ID_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ID_W-1:0]   pushId,
  input  cmd_e              pushCmd,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [PEND-1:0]   removeMask,
  input  logic [PEND-1:0]   setWaitMask,
  output logic              pendVld  [PEND],
  output logic [ID_W-1:0]   pendId   [PEND],
  output cmd_e              pendCmd  [PEND],
  output logic [ADDR_W-1:0] pendAddr [PEND],
  output logic              pendWait [PEND]
);

  localparam int PCW = $clog2(PEND + 1);

  logic              nVld  [PEND];
  logic [ID_W-1:0]   nId   [PEND];
  cmd_e              nCmd  [PEND];
  logic [ADDR_W-1:0] nAddr [PEND];
  logic              nWait [PEND];
  logic [PCW-1:0]    keepCnt;

  // Stable compaction keeps arrival order: slot 0 is the oldest.
  always_comb begin
    keepCnt = '0;
    for (int i = 0; i < PEND; i++) begin
      nVld[i]  = 1'b0;
      nId[i]   = '0;
      nCmd[i]  = CMD_GET;
      nAddr[i] = '0;
      nWait[i] = 1'b0;
    end
    for (int i = 0; i < PEND; i++) begin
      if (pendVld[i] && !removeMask[i]) begin
        nVld[keepCnt]  = 1'b1;
        nId[keepCnt]   = pendId[i];
        nCmd[keepCnt]  = pendCmd[i];
        nAddr[keepCnt] = pendAddr[i];
        nWait[keepCnt] = pendWait[i] | setWaitMask[i];
        keepCnt = keepCnt + PCW'(1);
      end
    end
    if (strb.queuePush && (keepCnt < PCW'(PEND))) begin
      nVld[keepCnt]  = 1'b1;
      nId[keepCnt]   = pushId;
      nCmd[keepCnt]  = pushCmd;
      nAddr[keepCnt] = pushAddr;
      nWait[keepCnt] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PEND; i++) begin
        pendVld[i]  <= 1'b0;
        pendId[i]   <= '0;
        pendCmd[i]  <= CMD_GET;
        pendAddr[i] <= '0;
        pendWait[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < PEND; i++) begin
        pendVld[i]  <= nVld[i];
        pendId[i]   <= nId[i];
        pendCmd[i]  <= nCmd[i];
        pendAddr[i] <= nAddr[i];
        pendWait[i] <= nWait[i];
      end
    end
  end

endmodule

// File: rtl/mmt_entries.sv
module mmt_entries
  import mmt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int DLY     = 4,
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 8,
  localparam int EW      = $clog2(ENTRIES),
  localparam int DCW     = $clog2(DLY + 1),
  localparam int NUM_IDS = 1 << ID_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [EW-1:0]      entryIdx,
  input  logic [ID_W-1:0]    insId,
  input  cmd_e               insCmd,
  input  logic [ADDR_W-1:0]  insAddr,
  input  logic [NUM_IDS-1:0] newMerge,
  input  logic [ID_W-1:0]    newDlyId  [DLY],
  input  cmd_e               newDlyCmd [DLY],
  input  logic [DCW-1:0]     newDlyCnt,
  output logic               entUsed    [ENTRIES],
  output logic [ADDR_W-1:0]  entAddr    [ENTRIES],
  output logic [ID_W-1:0]    entInitId  [ENTRIES],
  output cmd_e               entInitCmd [ENTRIES],
  output logic [NUM_IDS-1:0] entMerge   [ENTRIES],
  output logic [ID_W-1:0]    entDlyId   [ENTRIES][DLY],
  output cmd_e               entDlyCmd  [ENTRIES][DLY],
  output logic [DCW-1:0]     entDlyCnt  [ENTRIES]
);

  logic               headIsGet;
  logic [NUM_IDS-1:0] promMerge;
  logic [ID_W-1:0]    promId  [DLY];
  cmd_e               promCmd [DLY];
  logic [DCW-1:0]     promCnt;

  // Hold list of the target entry after its head is promoted
  always_comb begin
    headIsGet = (entDlyCmd[entryIdx][0] == CMD_GET);
    promMerge = '0;
    promCnt   = '0;
    for (int k = 0; k < DLY; k++) begin
      promId[k]  = '0;
      promCmd[k] = CMD_GET;
    end
    for (int k = 1; k < DLY; k++) begin
      if (DCW'(k) < entDlyCnt[entryIdx]) begin
        if (headIsGet && entDlyCmd[entryIdx][k] == CMD_GET) begin
          promMerge[entDlyId[entryIdx][k]] = 1'b1;
        end else begin
          promId[promCnt]  = entDlyId[entryIdx][k];
          promCmd[promCnt] = entDlyCmd[entryIdx][k];
          promCnt = promCnt + DCW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        entUsed[e]    <= 1'b0;
        entAddr[e]    <= '0;
        entInitId[e]  <= '0;
        entInitCmd[e] <= CMD_GET;
        entMerge[e]   <= '0;
        entDlyCnt[e]  <= '0;
        for (int k = 0; k < DLY; k++) begin
          entDlyId[e][k]  <= '0;
          entDlyCmd[e][k] <= CMD_GET;
        end
      end
    end else if (strb.insertEntry) begin
      entUsed[entryIdx]    <= 1'b1;
      entAddr[entryIdx]    <= insAddr;
      entInitId[entryIdx]  <= insId;
      entInitCmd[entryIdx] <= insCmd;
      entMerge[entryIdx]   <= newMerge;
      entDlyCnt[entryIdx]  <= newDlyCnt;
      for (int k = 0; k < DLY; k++) begin
        entDlyId[entryIdx][k]  <= newDlyId[k];
        entDlyCmd[entryIdx][k] <= newDlyCmd[k];
      end
    end else if (strb.completeEntry) begin
      if (strb.promoteHead) begin
        entInitId[entryIdx]  <= entDlyId[entryIdx][0];
        entInitCmd[entryIdx] <= entDlyCmd[entryIdx][0];
        entMerge[entryIdx]   <= promMerge;
        entDlyCnt[entryIdx]  <= promCnt;
        for (int k = 0; k < DLY; k++) begin
          entDlyId[entryIdx][k]  <= promId[k];
          entDlyCmd[entryIdx][k] <= promCmd[k];
        end
      end else begin
        entUsed[entryIdx]   <= 1'b0;
        entMerge[entryIdx]  <= '0;
        entDlyCnt[entryIdx] <= '0;
      end
    end
  end

endmodule

// File: rtl/mmt_ctrl.sv
module mmt_ctrl
  import mmt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int DLY     = 4,
  parameter int PEND    = 8,
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 8,
  parameter int STAT_W  = 2,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  localparam int EW      = $clog2(ENTRIES),
  localparam int DCW     = $clog2(DLY + 1),
  localparam int PW      = $clog2(PEND),
  localparam int NUM_IDS = 1 << ID_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  op_e                opKind,
  input  logic [ID_W-1:0]    opId,
  input  cmd_e               opCmd,
  input  logic               opShared,
  input  logic [ADDR_W-1:0]  opAddr,
  input  logic [STAT_W-1:0]  opStatus,
  input  logic [DATA_W-1:0]  opData,
  input  logic               pendVld  [PEND],
  input  logic [ID_W-1:0]    pendId   [PEND],
  input  cmd_e               pendCmd  [PEND],
  input  logic [ADDR_W-1:0]  pendAddr [PEND],
  input  logic               pendWait [PEND],
  input  logic               entUsed    [ENTRIES],
  input  logic [ADDR_W-1:0]  entAddr    [ENTRIES],
  input  logic [ID_W-1:0]    entInitId  [ENTRIES],
  input  cmd_e               entInitCmd [ENTRIES],
  input  logic [NUM_IDS-1:0] entMerge   [ENTRIES],
  input  logic [ID_W-1:0]    entDlyId   [ENTRIES][DLY],
  input  cmd_e               entDlyCmd  [ENTRIES][DLY],
  input  logic [DCW-1:0]     entDlyCnt  [ENTRIES],
  output ctrlStrobe_t        strb,
  output logic [EW-1:0]      entryIdx,
  output logic [PEND-1:0]    removeMask,
  output logic [PEND-1:0]    setWaitMask,
  output logic [NUM_IDS-1:0] newMerge,
  output logic [ID_W-1:0]    newDlyId  [DLY],
  output cmd_e               newDlyCmd [DLY],
  output logic [DCW-1:0]     newDlyCnt,
  output logic               respValid,
  output logic [NUM_IDS-1:0] respMask,
  output logic [STAT_W-1:0]  respStatus,
  output logic [DATA_W-1:0]  respData,
  output logic [EW-1:0]      respEntry,
  output logic               arbValid,
  output logic [ID_W-1:0]    arbId,
  output cmd_e               arbCmd,
  output logic [ADDR_W-1:0]  arbAddr,
  output logic [CNT_W-1:0]   mergeCount,
  output logic [CNT_W-1:0]   conflictCount
);

  localparam int FCW = $clog2(ENTRIES + 1);

  logic [FCW-1:0]     freeCnt;
  logic [EW-1:0]      freeIdx;
  logic               freeFound;
  logic [EW-1:0]      hitIdx;
  logic               hitFound;
  logic               lastFree;
  logic [PEND-1:0]    insRemove;
  logic [PW-1:0]      relIdx;
  logic               relFound;
  logic [NUM_IDS-1:0] answerMask;
  logic               initIsGet;

  // Lowest free entry and number of free entries
  always_comb begin
    freeCnt   = '0;
    freeIdx   = '0;
    freeFound = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!entUsed[e]) begin
        if (!freeFound) begin
          freeIdx   = EW'(e);
          freeFound = 1'b1;
        end
        freeCnt = freeCnt + FCW'(1);
      end
    end
    lastFree = (freeCnt == FCW'(1));
  end

  // Entry whose initiator carries the completing ID
  always_comb begin
    hitIdx   = '0;
    hitFound = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!hitFound && entUsed[e] && entInitId[e] == opId) begin
        hitIdx   = EW'(e);
        hitFound = 1'b1;
      end
    end
  end

  // Sorting of the pending pool against the inserted request
  always_comb begin
    insRemove   = '0;
    setWaitMask = '0;
    newMerge    = '0;
    newDlyCnt   = '0;
    for (int k = 0; k < DLY; k++) begin
      newDlyId[k]  = '0;
      newDlyCmd[k] = CMD_GET;
    end
    for (int p = 0; p < PEND; p++) begin
      if (pendVld[p] && pendAddr[p] == opAddr) begin
        if (pendCmd[p] == CMD_GET && opShared) begin
          newMerge[pendId[p]] = 1'b1;
          insRemove[p] = 1'b1;
        end else if (pendCmd[p] != CMD_WRITEBACK && newDlyCnt < DCW'(DLY)) begin
          newDlyId[newDlyCnt]  = pendId[p];
          newDlyCmd[newDlyCnt] = pendCmd[p];
          newDlyCnt = newDlyCnt + DCW'(1);
          insRemove[p] = 1'b1;
        end
      end else if (pendVld[p] && lastFree && !pendWait[p] &&
                   (pendCmd[p] == CMD_GET || pendCmd[p] == CMD_GETX)) begin
        setWaitMask[p] = 1'b1;
      end
    end
    if (!strb.insertEntry) setWaitMask = '0;
  end

  // Oldest request waiting for table space
  always_comb begin
    relIdx   = '0;
    relFound = 1'b0;
    for (int p = 0; p < PEND; p++) begin
      if (!relFound && pendVld[p] && pendWait[p]) begin
        relIdx   = PW'(p);
        relFound = 1'b1;
      end
    end
  end

  always_comb begin
    strb.queuePush     = (opKind == OP_QUEUE);
    strb.insertEntry   = (opKind == OP_INSERT) && freeFound;
    strb.completeEntry = (opKind == OP_COMPLETE) && hitFound;
    strb.promoteHead   = strb.completeEntry && (entDlyCnt[hitIdx] != '0);
    strb.releaseWaiter = strb.completeEntry && !strb.promoteHead && relFound;
    entryIdx = strb.insertEntry ? freeIdx : hitIdx;
    removeMask = '0;
    if (strb.insertEntry) begin
      removeMask = insRemove;
    end else if (strb.releaseWaiter) begin
      removeMask[relIdx] = 1'b1;
    end
    initIsGet  = (entInitCmd[hitIdx] == CMD_GET);
    answerMask = initIsGet ? entMerge[hitIdx] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respMask      <= '0;
      respStatus    <= '0;
      respData      <= '0;
      respEntry     <= '0;
      arbValid      <= 1'b0;
      arbId         <= '0;
      arbCmd        <= CMD_GET;
      arbAddr       <= '0;
      mergeCount    <= '0;
      conflictCount <= '0;
    end else begin
      respValid <= strb.completeEntry;
      arbValid  <= strb.promoteHead | strb.releaseWaiter;
      if (strb.completeEntry) begin
        respMask          <= answerMask;
        respMask[opId]    <= 1'b1;
        respStatus        <= opStatus;
        respData          <= opData;
        respEntry         <= hitIdx;
        mergeCount        <= mergeCount + CNT_W'($countones(answerMask));
      end
      if (strb.promoteHead) begin
        arbId         <= entDlyId[hitIdx][0];
        arbCmd        <= entDlyCmd[hitIdx][0];
        arbAddr       <= entAddr[hitIdx];
        conflictCount <= conflictCount + CNT_W'(1);
      end else if (strb.releaseWaiter) begin
        arbId   <= pendId[relIdx];
        arbCmd  <= pendCmd[relIdx];
        arbAddr <= pendAddr[relIdx];
      end
    end
  end

endmodule

// File: rtl/miss_merge_table.sv
module miss_merge_table
  import mmt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int DLY     = 4,
  parameter int PEND    = 8,
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 8,
  parameter int STAT_W  = 2,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  localparam int EW      = $clog2(ENTRIES),
  localparam int NUM_IDS = 1 << ID_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         opKind,
  input  logic [ID_W-1:0]    opId,
  input  logic [1:0]         opCmd,
  input  logic               opShared,
  input  logic [ADDR_W-1:0]  opAddr,
  input  logic [STAT_W-1:0]  opStatus,
  input  logic [DATA_W-1:0]  opData,
  output logic               respValid,
  output logic [NUM_IDS-1:0] respMask,
  output logic [STAT_W-1:0]  respStatus,
  output logic [DATA_W-1:0]  respData,
  output logic [EW-1:0]      respEntry,
  output logic               arbValid,
  output logic [ID_W-1:0]    arbId,
  output logic [1:0]         arbCmd,
  output logic [ADDR_W-1:0]  arbAddr,
  output logic [CNT_W-1:0]   mergeCount,
  output logic [CNT_W-1:0]   conflictCount
);

  localparam int DCW = $clog2(DLY + 1);

  ctrlStrobe_t        strb;
  logic [EW-1:0]      entryIdx;
  logic [PEND-1:0]    removeMask;
  logic [PEND-1:0]    setWaitMask;
  logic [NUM_IDS-1:0] newMerge;
  logic [ID_W-1:0]    newDlyId  [DLY];
  cmd_e               newDlyCmd [DLY];
  logic [DCW-1:0]     newDlyCnt;
  logic               pendVld  [PEND];
  logic [ID_W-1:0]    pendId   [PEND];
  cmd_e               pendCmd  [PEND];
  logic [ADDR_W-1:0]  pendAddr [PEND];
  logic               pendWait [PEND];
  logic               entUsed    [ENTRIES];
  logic [ADDR_W-1:0]  entAddr    [ENTRIES];
  logic [ID_W-1:0]    entInitId  [ENTRIES];
  cmd_e               entInitCmd [ENTRIES];
  logic [NUM_IDS-1:0] entMerge   [ENTRIES];
  logic [ID_W-1:0]    entDlyId   [ENTRIES][DLY];
  cmd_e               entDlyCmd  [ENTRIES][DLY];
  logic [DCW-1:0]     entDlyCnt  [ENTRIES];
  cmd_e               arbCmdE;

  assign arbCmd = arbCmdE;

  mmt_ctrl #(
    .ENTRIES(ENTRIES), .DLY(DLY), .PEND(PEND), .ID_W(ID_W), .ADDR_W(ADDR_W),
    .STAT_W(STAT_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .opKind(op_e'(opKind)), .opId(opId), .opCmd(cmd_e'(opCmd)), .opShared(opShared),
    .opAddr(opAddr), .opStatus(opStatus), .opData(opData),
    .pendVld(pendVld), .pendId(pendId), .pendCmd(pendCmd), .pendAddr(pendAddr),
    .pendWait(pendWait),
    .entUsed(entUsed), .entAddr(entAddr), .entInitId(entInitId), .entInitCmd(entInitCmd),
    .entMerge(entMerge), .entDlyId(entDlyId), .entDlyCmd(entDlyCmd), .entDlyCnt(entDlyCnt),
    .strb(strb), .entryIdx(entryIdx), .removeMask(removeMask), .setWaitMask(setWaitMask),
    .newMerge(newMerge), .newDlyId(newDlyId), .newDlyCmd(newDlyCmd), .newDlyCnt(newDlyCnt),
    .respValid(respValid), .respMask(respMask), .respStatus(respStatus),
    .respData(respData), .respEntry(respEntry),
    .arbValid(arbValid), .arbId(arbId), .arbCmd(arbCmdE), .arbAddr(arbAddr),
    .mergeCount(mergeCount), .conflictCount(conflictCount)
  );

  mmt_pending #(.PEND(PEND), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_pending (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pushId(opId), .pushCmd(cmd_e'(opCmd)), .pushAddr(opAddr),
    .removeMask(removeMask), .setWaitMask(setWaitMask),
    .pendVld(pendVld), .pendId(pendId), .pendCmd(pendCmd), .pendAddr(pendAddr),
    .pendWait(pendWait)
  );

  mmt_entries #(.ENTRIES(ENTRIES), .DLY(DLY), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_entries (
    .clk(clk), .rstN(rstN), .strb(strb), .entryIdx(entryIdx),
    .insId(opId), .insCmd(cmd_e'(opCmd)), .insAddr(opAddr),
    .newMerge(newMerge), .newDlyId(newDlyId), .newDlyCmd(newDlyCmd), .newDlyCnt(newDlyCnt),
    .entUsed(entUsed), .entAddr(entAddr), .entInitId(entInitId), .entInitCmd(entInitCmd),
    .entMerge(entMerge), .entDlyId(entDlyId), .entDlyCmd(entDlyCmd), .entDlyCnt(entDlyCnt)
  );

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int NUM_IDS = 8,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         opKind,
  input logic               respValid,
  input logic [NUM_IDS-1:0] respMask,
  input logic               arbValid,
  input logic [CNT_W-1:0]   mergeCount,
  input logic [CNT_W-1:0]   conflictCount
);

  // R10: responses only follow a completion operation
  p_resp_after_cmp_r10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(opKind) == 2'd3);

  // R3: a response always answers at least the initiator
  p_resp_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> respMask != '0);

  // R7: an arbitrate event only follows a completion that also responds
  p_arb_with_resp_r7: assert property (@(posedge clk) disable iff (!rstN)
    arbValid |-> respValid);

  // R4: conflict counter steps by one, together with an arbitrate event
  p_conflict_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    conflictCount != $past(conflictCount) |->
      (conflictCount == $past(conflictCount) + 1'b1) && arbValid);

  // R9: merge counter only moves with a response
  p_merge_with_resp_r9: assert property (@(posedge clk) disable iff (!rstN)
    mergeCount != $past(mergeCount) |-> respValid);

endmodule

bind miss_merge_table mmt_checker #(.NUM_IDS(NUM_IDS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .opKind(opKind), .respValid(respValid), .respMask(respMask),
  .arbValid(arbValid), .mergeCount(mergeCount), .conflictCount(conflictCount)
);

// File: tb/miss_merge_table_tb.sv
module miss_merge_table_tb;

  localparam int ID_W = 3, ADDR_W = 8, STAT_W = 2, DATA_W = 8, CNT_W = 8;
  localparam int NUM_IDS = 1 << ID_W;
  localparam logic [1:0] QUE = 2'd1, INS = 2'd2, CMP = 2'd3;
  localparam logic [1:0] GET = 2'd0, GETX = 2'd1, UPG = 2'd2, WB = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] opKind = '0;
  logic [ID_W-1:0] opId = '0;
  logic [1:0] opCmd = '0;
  logic opShared = 1'b0;
  logic [ADDR_W-1:0] opAddr = '0;
  logic [STAT_W-1:0] opStatus = '0;
  logic [DATA_W-1:0] opData = '0;
  logic respValid, arbValid;
  logic [NUM_IDS-1:0] respMask;
  logic [STAT_W-1:0] respStatus;
  logic [DATA_W-1:0] respData;
  logic [1:0] respEntry;
  logic [ID_W-1:0] arbId;
  logic [1:0] arbCmd;
  logic [ADDR_W-1:0] arbAddr;
  logic [CNT_W-1:0] mergeCount, conflictCount;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  miss_merge_table u_dut (
    .clk(clk), .rstN(rstN), .opKind(opKind), .opId(opId), .opCmd(opCmd),
    .opShared(opShared), .opAddr(opAddr), .opStatus(opStatus), .opData(opData),
    .respValid(respValid), .respMask(respMask), .respStatus(respStatus),
    .respData(respData), .respEntry(respEntry), .arbValid(arbValid), .arbId(arbId),
    .arbCmd(arbCmd), .arbAddr(arbAddr), .mergeCount(mergeCount),
    .conflictCount(conflictCount)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one operation; return at the next falling edge, when its results show.
  task automatic doOp(logic [1:0] k, logic [ID_W-1:0] id, logic [1:0] c, logic sh,
                      logic [ADDR_W-1:0] a, logic [STAT_W-1:0] st, logic [DATA_W-1:0] d);
    @(negedge clk);
    opKind = k; opId = id; opCmd = c; opShared = sh; opAddr = a; opStatus = st; opData = d;
    @(negedge clk);
    opKind = 2'd0;
  endtask

  task automatic queueReq(logic [ID_W-1:0] id, logic [1:0] c, logic [ADDR_W-1:0] a);
    doOp(QUE, id, c, 1'b0, a, '0, '0);
  endtask

  task automatic insertReq(logic [ID_W-1:0] id, logic [1:0] c, logic sh, logic [ADDR_W-1:0] a);
    doOp(INS, id, c, sh, a, '0, '0);
  endtask

  task automatic completeReq(logic [ID_W-1:0] id, logic [STAT_W-1:0] st, logic [DATA_W-1:0] d);
    doOp(CMP, id, 2'd0, 1'b0, '0, st, d);
  endtask

  task automatic testReset();
    chk("R1", "respValid", 32'(respValid), 0);
    chk("R1", "arbValid", 32'(arbValid), 0);
    chk("R1", "mergeCount", 32'(mergeCount), 0);
    chk("R1", "conflictCount", 32'(conflictCount), 0);
  endtask

  task automatic testMerge();
    queueReq(3'd1, GET, 8'h10);
    queueReq(3'd2, GET, 8'h10);
    insertReq(3'd0, GET, 1'b1, 8'h10);
    completeReq(3'd0, 2'd2, 8'hA5);
    chk("R3", "respValid", 32'(respValid), 1);
    chk("R3", "respMask", 32'(respMask), 32'h07);
    chk("R3", "respStatus", 32'(respStatus), 2);
    chk("R3", "respData", 32'(respData), 32'hA5);
    chk("R2", "respEntry", 32'(respEntry), 0);
    chk("R9", "mergeCount", 32'(mergeCount), 2);
    chk("R3", "arbValid", 32'(arbValid), 0);
  endtask

  task automatic testDelay();
    queueReq(3'd1, GETX, 8'h20);
    queueReq(3'd2, UPG, 8'h20);
    queueReq(3'd3, WB, 8'h20);
    insertReq(3'd0, GET, 1'b0, 8'h20);
    completeReq(3'd0, 2'd1, 8'h11);
    chk("R4", "respMask", 32'(respMask), 32'h01);
    chk("R4", "arbValid", 32'(arbValid), 1);
    chk("R4", "arbId", 32'(arbId), 1);
    chk("R4", "arbCmd", 32'(arbCmd), 32'(GETX));
    chk("R4", "arbAddr", 32'(arbAddr), 32'h20);
    chk("R4", "conflictCount", 32'(conflictCount), 1);
    completeReq(3'd1, 2'd1, 8'h12);
    chk("R4", "respMask 2nd", 32'(respMask), 32'h02);
    chk("R4", "arbId 2nd", 32'(arbId), 2);
    chk("R4", "arbCmd 2nd", 32'(arbCmd), 32'(UPG));
    chk("R4", "conflictCount 2nd", 32'(conflictCount), 2);
    completeReq(3'd2, 2'd1, 8'h13);
    chk("R6", "respMask excludes writeback", 32'(respMask), 32'h04);
    chk("R6", "no arbitrate for writeback", 32'(arbValid), 0);
  endtask

  task automatic testPromoteGet();
    queueReq(3'd1, GET, 8'h30);
    queueReq(3'd2, GETX, 8'h30);
    queueReq(3'd3, GET, 8'h30);
    insertReq(3'd0, GETX, 1'b0, 8'h30);
    completeReq(3'd0, 2'd0, 8'h21);
    chk("R5", "arbId head GET", 32'(arbId), 1);
    chk("R5", "arbCmd head GET", 32'(arbCmd), 32'(GET));
    completeReq(3'd1, 2'd3, 8'h22);
    chk("R5", "respMask GET with joined GET", 32'(respMask), 32'h0A);
    chk("R5", "respData", 32'(respData), 32'h22);
    chk("R9", "mergeCount", 32'(mergeCount), 3);
    chk("R5", "arbId held GETX", 32'(arbId), 2);
    chk("R4", "conflictCount", 32'(conflictCount), 4);
    completeReq(3'd2, 2'd0, 8'h23);
    chk("R5", "respMask last", 32'(respMask), 32'h04);
    chk("R5", "arbValid last", 32'(arbValid), 0);
  endtask

  task automatic testOverflow();
    queueReq(3'd5, GET, 8'h50);
    queueReq(3'd6, GETX, 8'h60);
    queueReq(3'd7, UPG, 8'h70);
    insertReq(3'd0, GET, 1'b1, 8'h40);
    insertReq(3'd1, GET, 1'b1, 8'h41);
    insertReq(3'd2, GET, 1'b1, 8'h42);
    insertReq(3'd4, GET, 1'b1, 8'h44);
    insertReq(3'd3, GET, 1'b1, 8'h45);
    completeReq(3'd3, 2'd0, 8'h00);
    chk("R2", "insert into full table ignored", 32'(respValid), 0);
    completeReq(3'd1, 2'd0, 8'h31);
    chk("R2", "respEntry", 32'(respEntry), 1);
    chk("R7", "arbValid release", 32'(arbValid), 1);
    chk("R7", "arbId oldest waiter", 32'(arbId), 5);
    chk("R7", "arbAddr oldest waiter", 32'(arbAddr), 32'h50);
    insertReq(3'd3, GET, 1'b1, 8'h43);
    completeReq(3'd3, 2'd0, 8'h32);
    chk("R2", "lowest free entry reused", 32'(respEntry), 1);
    chk("R7", "arbId second waiter", 32'(arbId), 6);
    chk("R7", "arbCmd second waiter", 32'(arbCmd), 32'(GETX));
    completeReq(3'd2, 2'd0, 8'h33);
    chk("R2", "respEntry", 32'(respEntry), 2);
    chk("R7", "upgrade not waiting", 32'(arbValid), 0);
    completeReq(3'd6, 2'd0, 8'h34);
    chk("R10", "unknown completion respValid", 32'(respValid), 0);
    chk("R10", "unknown completion arbValid", 32'(arbValid), 0);
    completeReq(3'd0, 2'd0, 8'h35);
    completeReq(3'd4, 2'd0, 8'h36);
    chk("R2", "last entry respEntry", 32'(respEntry), 3);
  endtask

  task automatic testWaiterMerge();
    queueReq(3'd5, GET, 8'h77);
    queueReq(3'd6, GET, 8'h78);
    insertReq(3'd0, GET, 1'b1, 8'h81);
    insertReq(3'd1, GET, 1'b1, 8'h82);
    insertReq(3'd2, GET, 1'b1, 8'h83);
    insertReq(3'd3, GET, 1'b1, 8'h84);
    completeReq(3'd0, 2'd0, 8'h40);
    chk("R7", "arbId release", 32'(arbId), 5);
    insertReq(3'd4, GET, 1'b1, 8'h78);
    completeReq(3'd4, 2'd1, 8'h41);
    chk("R8", "respMask waiter merged", 32'(respMask), 32'h50);
    chk("R8", "no waiter left", 32'(arbValid), 0);
    chk("R9", "mergeCount", 32'(mergeCount), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMerge();
    testDelay();
    testPromoteGet();
    testOverflow();
    testWaiterMerge();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule